// File: doc/BRIEF.md
# Next Program Counter Steering Unit

This block works out the address of the next instruction for a single-issue 32-bit RISC core. Each cycle the core presents the current program counter, the low 26 bits of the fetched instruction word, the two source register values and a control class that the decoder has already chosen. The unit returns the address to fetch next. For a call it also returns the return address and the index of the register that receives it. The unit is purely combinational. It has no state and no clock.

Every target starts from the incremented address (current PC plus 4). A conditional branch adds a signed word offset to that address. A direct jump keeps the top four bits of the incremented address and replaces the rest with the 26-bit field shifted left by two. A register jump takes the first source value as the target, unchanged. Fetch, pipelining, delay slots and prediction are handled outside this block.

Top module: `next_pc_unit`

## Requirements
- R1: With class code 0 (sequential), or with an unassigned code 6 or 7, `next_pc` equals `cur_pc + 4` modulo 2^32.
- R2: With class code 1 (branch on equal) and `src_a == src_b`, `next_pc` equals `cur_pc + 4 + 4 * sext(instr_lo[15:0])`.
- R3: A branch that is not taken gives `next_pc = cur_pc + 4`. This covers code 1 with unequal sources and code 2 with equal sources.
- R4: With class code 2 (branch on not equal) and `src_a != src_b`, `next_pc` is the branch target defined in R2.
- R5: With class code 3 (direct jump), `next_pc` equals `{(cur_pc+4)[31:28], instr_lo[25:0], 2'b00}`.
- R6: With class code 4 (jump and link), `next_pc` follows R5, `link_we` is 1, `link_val` equals `cur_pc + 4` and `link_idx` is 31.
- R7: With class code 5 (register jump), `next_pc` equals `src_a` on all 32 bits, including the low two.
- R8: `link_we` is 0 for every class code except 4. `link_val` always shows `cur_pc + 4` and `link_idx` always shows 31.
- R9: All address sums wrap modulo 2^32. Sequential flow from 0xFFFFFFFC gives 0, and a backward branch near address 0 wraps to the top of the address space.
- R10: The region bits of a direct jump come from the incremented PC. When `cur_pc` is 0x0FFFFFFC, the jump lands in region 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the current instruction |
| instr_lo | input | 26 | Low 26 bits of the instruction word: the jump field, with the branch offset in bits 15:0 |
| src_a | input | 32 | First source register value (compare operand and register-jump target) |
| src_b | input | 32 | Second source register value (compare operand) |
| xfer_class | input | 3 | Decoded class: 0 seq, 1 branch-equal, 2 branch-not-equal, 3 jump, 4 jump-and-link, 5 register jump |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Return-address write enable |
| link_val | output | 32 | Return address (current PC plus 4) |
| link_idx | output | 5 | Register that receives the return address |

## Verification
The unit holds no state, so a wrong internal value cannot linger. A faulty adder, sign extension, region splice or select term shows on `next_pc` or the link outputs for the same input vector, before the next clock edge. The vectors are chosen so that each fault produces a distinct wrong address. The offsets cover the largest positive and negative values, and branches cross zero and the top of the address space. Jumps run from the last word of one 256 MB region into the next, and register jumps use targets that are not word aligned.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  parameter int NPC_XLEN   = 32;
  parameter int NPC_OFF_W  = 16;
  parameter int NPC_JFLD_W = 26;
  parameter int NPC_REG_W  = 5;
  localparam int NPC_REGION_W = NPC_XLEN - NPC_JFLD_W - 2;
  localparam int NPC_CLS_W    = 3;

  typedef enum logic [NPC_CLS_W-1:0] {
    XF_SEQ = 3'd0,
    XF_BEQ = 3'd1,
    XF_BNE = 3'd2,
    XF_JMP = 3'd3,
    XF_JAL = 3'd4,
    XF_JR  = 3'd5
  } xfer_e;

  // Incremented address: one word ahead.
  function automatic logic [NPC_XLEN-1:0] f_step(input logic [NPC_XLEN-1:0] pc);
    return pc + NPC_XLEN'(4);
  endfunction

  // Branch target: incremented PC plus a sign-extended word offset.
  function automatic logic [NPC_XLEN-1:0] f_branch(input logic [NPC_XLEN-1:0] step,
                                                   input logic [NPC_OFF_W-1:0] off);
    logic [NPC_XLEN-1:0] ext;
    ext = {{(NPC_XLEN-NPC_OFF_W-2){off[NPC_OFF_W-1]}}, off, 2'b00};
    return step + ext;
  endfunction

  // Direct jump target: region bits of the incremented PC and the word-aligned field.
  function automatic logic [NPC_XLEN-1:0] f_jump(input logic [NPC_XLEN-1:0] step,
                                                 input logic [NPC_JFLD_W-1:0] fld);
    return {step[NPC_XLEN-1 -: NPC_REGION_W], fld, 2'b00};
  endfunction
endpackage

// File: rtl/npc_step_adder.sv
`timescale 1ns/1ps
module npc_step_adder
  import npc_pkg::*;
#(
  parameter int XLEN = NPC_XLEN
) (
  input  logic [XLEN-1:0] pc_in,
  output logic [XLEN-1:0] pc_step
);
  always_comb begin
    pc_step = f_step(pc_in);
    // R9: the increment is exactly one word, modulo 2^XLEN
    step_word_chk: assert ((pc_step - pc_in) == XLEN'(4))
      else $error("step adder did not advance by one word");
  end
endmodule

// File: rtl/npc_branch_unit.sv
`timescale 1ns/1ps
module npc_branch_unit
  import npc_pkg::*;
#(
  parameter int XLEN  = NPC_XLEN,
  parameter int OFF_W = NPC_OFF_W
) (
  input  logic [XLEN-1:0]  step_pc,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic             want_eq,
  input  logic             want_ne,
  output logic [XLEN-1:0]  br_target,
  output logic             br_taken
);
  logic same;

  always_comb begin
    same      = (opnd_a == opnd_b);
    br_target = f_branch(step_pc, offset);
    br_taken  = (want_eq & same) | (want_ne & ~same);
    // R2 R4: the distance from the incremented PC is a whole number of words
    br_align_chk: assert (br_target[1:0] == step_pc[1:0])
      else $error("branch target lost word alignment relative to the incremented PC");
  end
endmodule

// File: rtl/npc_jump_unit.sv
`timescale 1ns/1ps
module npc_jump_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = NPC_XLEN,
  parameter int JFLD_W = NPC_JFLD_W
) (
  input  logic [XLEN-1:0]   step_pc,
  input  logic [JFLD_W-1:0] jfield,
  output logic [XLEN-1:0]   jmp_target
);
  localparam int RW = XLEN - JFLD_W - 2;

  always_comb begin
    jmp_target = f_jump(step_pc, jfield);
    // R10: the region comes from the incremented PC
    jmp_region_chk: assert (jmp_target[XLEN-1 -: RW] == step_pc[XLEN-1 -: RW])
      else $error("jump region differs from the incremented PC");
    // R5: direct jump targets are word aligned
    jmp_align_chk: assert (jmp_target[1:0] == 2'b00)
      else $error("jump target not word aligned");
  end
endmodule

// File: rtl/next_pc_unit.sv
`timescale 1ns/1ps
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = NPC_XLEN,
  parameter int OFF_W    = NPC_OFF_W,
  parameter int JFLD_W   = NPC_JFLD_W,
  parameter int REG_W    = NPC_REG_W,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [JFLD_W-1:0]    instr_lo,
  input  logic [XLEN-1:0]      src_a,
  input  logic [XLEN-1:0]      src_b,
  input  logic [NPC_CLS_W-1:0] xfer_class,
  output logic [XLEN-1:0]      next_pc,
  output logic                 link_we,
  output logic [XLEN-1:0]      link_val,
  output logic [REG_W-1:0]     link_idx
);
  logic [XLEN-1:0] pc_step;
  logic [XLEN-1:0] br_target;
  logic            br_taken;
  logic [XLEN-1:0] jmp_target;
  logic            is_beq, is_bne, is_jmp, is_jal, is_jr;
  xfer_e           cls;

  always_comb begin
    cls    = xfer_e'(xfer_class);
    is_beq = (cls == XF_BEQ);
    is_bne = (cls == XF_BNE);
    is_jmp = (cls == XF_JMP);
    is_jal = (cls == XF_JAL);
    is_jr  = (cls == XF_JR);
  end

  npc_step_adder #(.XLEN(XLEN)) u_step (
    .pc_in  (cur_pc),
    .pc_step(pc_step)
  );

  npc_branch_unit #(.XLEN(XLEN), .OFF_W(OFF_W)) u_br (
    .step_pc  (pc_step),
    .offset   (instr_lo[OFF_W-1:0]),
    .opnd_a   (src_a),
    .opnd_b   (src_b),
    .want_eq  (is_beq),
    .want_ne  (is_bne),
    .br_target(br_target),
    .br_taken (br_taken)
  );

  npc_jump_unit #(.XLEN(XLEN), .JFLD_W(JFLD_W)) u_jmp (
    .step_pc   (pc_step),
    .jfield    (instr_lo),
    .jmp_target(jmp_target)
  );

  always_comb begin
    if (is_jr)                 next_pc = src_a;
    else if (is_jmp || is_jal) next_pc = jmp_target;
    else if (br_taken)         next_pc = br_target;
    else                       next_pc = pc_step;
    link_we  = is_jal;
    link_val = pc_step;
    link_idx = REG_W'(LINK_REG);

    // R8: a link write happens only for jump-and-link
    link_only_jal_chk: assert (!link_we || xfer_class == 3'd4)
      else $error("link write outside jump-and-link");
    // R1 R3: without a transfer the next address is the incremented PC
    fallthru_chk: assert (is_jr || is_jmp || is_jal || br_taken || next_pc == pc_step)
      else $error("fall-through address is not the incremented PC");
    // R7: a register jump takes the source value untouched
    jr_pass_chk: assert (!is_jr || next_pc == src_a)
      else $error("register jump altered its target");
    // R2 R4: a taken branch never coincides with a jump class
    taken_excl_chk: assert (!br_taken || (!is_jmp && !is_jal && !is_jr))
      else $error("branch taken under a jump class");
  end
endmodule

// File: tb/sim_next_pc_unit.sv
`timescale 1ns/1ps
module sim_next_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [25:0] instr_lo = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [2:0]  xfer_class = '0;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  always #10 clk = ~clk;  // 50 MHz

  next_pc_unit u0 (
    .cur_pc(cur_pc), .instr_lo(instr_lo), .src_a(src_a), .src_b(src_b),
    .xfer_class(xfer_class), .next_pc(next_pc), .link_we(link_we),
    .link_val(link_val), .link_idx(link_idx)
  );

  typedef struct {
    logic [31:0] nxt;
    logic        we;
    logic [31:0] lv;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Independent reference model, in signed integer arithmetic.
  function automatic logic [31:0] model_next(logic [31:0] pc, logic [25:0] lo,
                                             logic [31:0] a, logic [31:0] b, logic [2:0] c);
    longint seq, off;
    seq = (longint'(pc) + 4) % 64'h1_0000_0000;
    off = longint'($signed(lo[15:0])) * 4;
    case (c)
      3'd1: return (a == b) ? 32'(seq + off) : 32'(seq);
      3'd2: return (a != b) ? 32'(seq + off) : 32'(seq);
      3'd3, 3'd4: return (32'(seq) & 32'hF000_0000) | (32'(lo) * 4);
      3'd5: return a;
      default: return 32'(seq);
    endcase
  endfunction

  task automatic drive(input logic [31:0] pc, input logic [25:0] lo,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] c, input logic [31:0] exp_nxt, input string tag);
    exp_t e;
    @(negedge clk);
    cur_pc = pc; instr_lo = lo; src_a = a; src_b = b; xfer_class = c;
    e.nxt = exp_nxt;
    e.we  = (c == 3'd4);
    e.lv  = pc + 32'd4;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drive_m(input logic [31:0] pc, input logic [25:0] lo,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] c, input string tag);
    drive(pc, lo, a, b, c, model_next(pc, lo, a, b, c), tag);
  endtask

  // Monitor: outputs settle half a cycle after the negedge drive.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      bit bad;
      e = sb_q.pop_front();
      n_vec++;
      bad = 0;
      if (next_pc !== e.nxt) begin
        $display("FAIL %s next_pc act=%08h exp=%08h", e.tag, next_pc, e.nxt); bad = 1;
      end
      if (link_we !== e.we) begin
        $display("FAIL %s link_we act=%0b exp=%0b", e.tag, link_we, e.we); bad = 1;
      end
      if (link_val !== e.lv) begin
        $display("FAIL %s link_val act=%08h exp=%08h", e.tag, link_val, e.lv); bad = 1;
      end
      if (link_idx !== 5'd31) begin
        $display("FAIL %s link_idx act=%0d exp=31", e.tag, link_idx); bad = 1;
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs behave as sequential flow (R1, R8)
    drive(32'h0, 26'h0, 32'h0, 32'h0, 3'd0, 32'h0000_0004, "R1 idle");
    drive(32'h0040_0100, 26'h3FF_FFFF, 32'h1, 32'h2, 3'd0, 32'h0040_0104, "R1 seq");
    drive(32'h0040_0100, 26'h0, 32'h5, 32'h5, 3'd6, 32'h0040_0104, "R1 code6");
    drive(32'h0040_0100, 26'h0, 32'h5, 32'h5, 3'd7, 32'h0040_0104, "R1 code7");
    // Branch on equal
    drive(32'h0001_0000, 26'h0000_0003, 32'h7, 32'h7, 3'd1, 32'h0001_0010, "R2 beq fwd");
    drive(32'h0001_0000, 26'h0000_FFFE, 32'h7, 32'h7, 3'd1, 32'h0000_FFFC, "R2 beq back");
    drive(32'h0001_0000, 26'h0000_7FFF, 32'h0, 32'h0, 3'd1, 32'h0003_0000, "R2 beq max+");
    drive(32'h0004_0000, 26'h0000_8000, 32'h0, 32'h0, 3'd1, 32'h0002_0004, "R2 beq max-");
    drive(32'h0001_0000, 26'h0000_0003, 32'h7, 32'h8, 3'd1, 32'h0001_0004, "R3 beq not taken");
    drive(32'h0001_0000, 26'h0000_0003, 32'h9, 32'h9, 3'd2, 32'h0001_0004, "R3 bne not taken");
    // Branch on not equal
    drive(32'h0001_0000, 26'h0000_0010, 32'hFFFF_FFFF, 32'h1, 3'd2, 32'h0001_0044, "R4 bne fwd");
    drive(32'h0001_0000, 26'h0000_FFF0, 32'h0, 32'h8000_0000, 3'd2, 32'h0000_FFC4, "R4 bne back");
    // Direct jump and jump-and-link
    drive(32'h8000_1000, 26'h0123_4567, 32'h0, 32'h0, 3'd3, 32'h848D_159C, "R5 jmp");
    drive(32'h4000_0020, 26'h0000_0100, 32'h0, 32'h0, 3'd4, 32'h4000_0400, "R6 jal");
    // Register jump, unaligned target kept
    drive(32'h0000_2000, 26'h0, 32'h1234_5677, 32'h0, 3'd5, 32'h1234_5677, "R7 jr");
    drive(32'h0000_2000, 26'h0, 32'hFFFF_FFFE, 32'h0, 3'd5, 32'hFFFF_FFFE, "R7 R8 jr no link");
    // Wrap-around
    drive(32'hFFFF_FFFC, 26'h0, 32'h0, 32'h0, 3'd0, 32'h0000_0000, "R9 seq wrap");
    drive(32'h0000_0000, 26'h0000_FFF0, 32'h3, 32'h3, 3'd1, 32'hFFFF_FFC4, "R9 beq wrap low");
    drive(32'hFFFF_FFF8, 26'h0000_0004, 32'h3, 32'h4, 3'd2, 32'h0000_000C, "R9 bne wrap high");
    // Region boundary: incremented PC decides the region
    drive(32'h0FFF_FFFC, 26'h0000_0040, 32'h0, 32'h0, 3'd3, 32'h1000_0100, "R10 jmp region");
    drive(32'h0FFF_FFFC, 26'h0000_0040, 32'h0, 32'h0, 3'd4, 32'h1000_0100, "R10 R6 jal region");
    drive(32'hFFFF_FFFC, 26'h3FF_FFFF, 32'h0, 32'h0, 3'd3, 32'h0FFF_FFFC, "R10 jmp top wrap");
    // Sweep of offsets in both directions and jump fields across regions
    for (int i = 0; i < 32; i++) begin
      logic [15:0] off;
      off = (i % 2 == 0) ? 16'(i * 1021) : 16'(-(i * 1021));
      drive_m(32'h7FFF_0000 + 32'(i * 4), {10'h0, off}, 32'(i), 32'(i), 3'd1, "R2 sweep");
      drive_m(32'h7FFF_0000 + 32'(i * 4), {10'h0, off}, 32'(i), 32'(i + 1), 3'd2, "R4 sweep");
    end
    for (int r = 0; r < 16; r++) begin
      drive_m({4'(r), 28'hFFF_FFFC}, 26'(r * 32'h0012_3457), 32'h0, 32'h0, 3'd3, "R5 R10 sweep");
      drive_m({4'(r), 28'h000_0010}, 26'(r * 32'h0003_1111), 32'h0, 32'h0, 3'd4, "R6 sweep");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule